// File: doc/BRIEF.md
# Prefetching Local Bus Master

This block is the master side of a narrow on-board local bus whose address and data share one set of lines. A host-side agent hands it single register reads and writes. The slave, in turn, can ask the master to pull a stream of data out of it. The slave makes that request by holding its active-low ready line low while the bus is quiet. The master answers with a block read from the fixed address zero and stores every word it receives in an internal prefetch FIFO. The host drains that FIFO through a valid/ready port.

Register accesses take priority over prefetching. If the host asks for a register access while a block read is running, the master asserts the active-low burst-last line on the current data cycle. That closes the burst, and the register address phase follows on the next cycle. A burst also closes itself with burst-last on the data cycle that fills the last free FIFO slot, so no word fetched from the slave is ever dropped.

The sequencer has six states:
- IDLE: waits for work.
- REG_ADDR: address phase of a register access.
- REG_DATA: data phase of a register access, held until the slave is ready.
- REG_DONE: a one-cycle acknowledge to the host.
- PF_ADDR: address phase of a prefetch burst.
- PF_DATA: the repeating data phase of a prefetch burst.

Its transitions are:
- IDLE to REG_ADDR when a request is present.
- IDLE to PF_ADDR when the slave requests and the FIFO is not full.
- REG_ADDR to REG_DATA.
- REG_DATA to REG_DONE when ready is low.
- REG_DONE to PF_ADDR, or to IDLE, by the same prefetch test as IDLE.
- PF_ADDR to PF_DATA.
- PF_DATA to REG_ADDR or IDLE on its last cycle, depending on whether a request is present.

The host raises `reg_req` with its fields and holds them stable until it sees `reg_ack`. It drops the request in the acknowledge cycle.

Top module: `lbm_prefetch_master`

## Requirements
- R1: While reset is active, and in the first cycle after reset, the master is idle: `lb_ads_n`=1, `lb_blast_n`=1, `lb_ad_oe`=0, `reg_ack`=0, `pf_empty`=1, `pf_count`=0, `pf_valid`=0.
- R2: Register write. The first cycle after the request drives `lb_ads_n`=0, the address zero-extended on `lb_ad_out`, `lb_ad_oe`=1 and `lb_wnr`=1. Every later cycle drives `lb_ads_n`=1, `lb_blast_n`=0, `lb_ad_oe`=1 and the write data, until a cycle with `lb_ready_n`=0. `reg_ack` is 1 in the cycle after that one.
- R3: Register read. The address phase has `lb_wnr`=0. The data phases have `lb_ad_oe`=0 and `lb_blast_n`=0. The `lb_ad_in` value present in the cycle with `lb_ready_n`=0 appears on `reg_rdata` in the `reg_ack` cycle.
- R4: In IDLE with no request, `lb_ready_n`=0 and the FIFO not full, the next cycle is a prefetch address phase: `lb_ads_n`=0, `lb_ad_out`=0, `lb_wnr`=0. Data phases follow with `lb_ad_oe`=0.
- R5: When the FIFO is full, a low `lb_ready_n` starts no burst, and `lb_ads_n` stays 1.
- R6: Each prefetch data cycle with `lb_ready_n`=0 stores `lb_ad_in` in the FIFO. Words leave on `pf_data` in arrival order, one per cycle with `pf_valid`=1 and `pf_ready`=1.
- R7: A request present in a prefetch data cycle drives `lb_blast_n`=0 in that same cycle. That cycle is the burst's last: its word is stored only if `lb_ready_n`=0. The register address phase is the next cycle.
- R8: `lb_blast_n`=0 on any prefetch data cycle in which `pf_count` is DEPTH-1. `pf_count` never exceeds DEPTH, and `pf_full` is 1 at DEPTH.
- R9: If `lb_ready_n` is 0 in the acknowledge cycle of a register access and the FIFO is not full, a prefetch address phase follows in the next cycle.
- R10: A register request and a prefetch request seen together in IDLE start the register access.
- R11: `pf_count` tracks stores minus removals, `pf_empty` is 1 at zero, and `pf_valid` equals not `pf_empty`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_req | input | 1 | Register access request, held until `reg_ack` |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Write data |
| reg_ack | output | 1 | One-cycle completion pulse |
| reg_rdata | output | DATA_W | Read data, valid with `reg_ack` |
| pf_valid | output | 1 | FIFO head word available |
| pf_data | output | DATA_W | FIFO head word |
| pf_ready | input | 1 | Host takes the head word |
| pf_count | output | CNT_W | Words stored |
| pf_full | output | 1 | FIFO full |
| pf_empty | output | 1 | FIFO empty |
| lb_ads_n | output | 1 | Active-low address strobe |
| lb_ad_out | output | DATA_W | Address/data lines, driven value |
| lb_ad_oe | output | 1 | Drive enable for the address/data lines |
| lb_ad_in | input | DATA_W | Address/data lines, sampled value |
| lb_wnr | output | 1 | 1 = write, 0 = read |
| lb_blast_n | output | 1 | Active-low burst-last |
| lb_ready_n | input | 1 | Active-low slave ready / prefetch request |

## Verification
Bus outputs are combinational from the state. The exception is `lb_blast_n` in a prefetch data cycle, which reacts to `reg_req` in the same cycle. The bench therefore drives its inputs on the falling edge and reads the bus a moment later, within that same cycle.

Several results land one cycle after a rising edge:
- An address strobe appears one cycle after the request that caused it.
- `reg_ack` and `reg_rdata` appear one cycle after the ready data phase.
- A stored word shows in `pf_count` one cycle after its data cycle.

The bench's own queue and register-file models advance at the sample point for the coming edge. Each count and data comparison is then made against the state those models held before that edge.

// File: rtl/lbm_pkg.sv
`timescale 1ns/1ps
package lbm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REG_ADDR = 3'd1,
        ST_REG_DATA = 3'd2,
        ST_REG_DONE = 3'd3,
        ST_PF_ADDR  = 3'd4,
        ST_PF_DATA  = 3'd5
    } lbm_state_t;

endpackage

// File: rtl/lbm_fifo.sv
`timescale 1ns/1ps
module lbm_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  count,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT  = CNT_W'(DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic              do_push, do_pop;

    assign full    = (count == FULL_CNT);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign head    = store[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) begin
                wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + PTR_W'(1);
            end
            if (do_pop) begin
                rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + PTR_W'(1);
            end
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CNT_W'(1);
                2'b01:   count <= count - CNT_W'(1);
                default: count <= count;
            endcase
        end
    end

endmodule

// File: rtl/lbm_seq.sv
`timescale 1ns/1ps
module lbm_seq
    import lbm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ack,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [CNT_W-1:0]  fifo_count,
    input  logic              fifo_full,
    output logic              push,
    output logic              lb_ads_n,
    output logic [DATA_W-1:0] lb_ad_out,
    output logic              lb_ad_oe,
    input  logic [DATA_W-1:0] lb_ad_in,
    output logic              lb_wnr,
    output logic              lb_blast_n,
    input  logic              lb_ready_n,
    output lbm_state_t        state
);
    localparam logic [CNT_W-1:0] NEAR_FULL = CNT_W'(DEPTH - 1);

    lbm_state_t state_nxt;
    logic       pf_wanted;
    logic       pf_last;

    assign pf_wanted = !lb_ready_n && !fifo_full;
    assign pf_last   = reg_req || (fifo_count >= NEAR_FULL);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nxt;
        end
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (reg_req) begin
                    state_nxt = ST_REG_ADDR;
                end else if (pf_wanted) begin
                    state_nxt = ST_PF_ADDR;
                end
            end
            ST_REG_ADDR: state_nxt = ST_REG_DATA;
            ST_REG_DATA: begin
                if (!lb_ready_n) begin
                    state_nxt = ST_REG_DONE;
                end
            end
            ST_REG_DONE: state_nxt = pf_wanted ? ST_PF_ADDR : ST_IDLE;
            ST_PF_ADDR:  state_nxt = ST_PF_DATA;
            ST_PF_DATA: begin
                if (pf_last) begin
                    state_nxt = reg_req ? ST_REG_ADDR : ST_IDLE;
                end
            end
            default:     state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        lb_ads_n   = 1'b1;
        lb_blast_n = 1'b1;
        lb_ad_out  = '0;
        lb_ad_oe   = 1'b0;
        lb_wnr     = 1'b0;
        reg_ack    = 1'b0;
        push       = 1'b0;
        unique case (state)
            ST_IDLE: begin
            end
            ST_REG_ADDR: begin
                lb_ads_n  = 1'b0;
                lb_ad_oe  = 1'b1;
                lb_ad_out = DATA_W'(reg_addr);
                lb_wnr    = reg_we;
            end
            ST_REG_DATA: begin
                lb_blast_n = 1'b0;
                lb_wnr     = reg_we;
                lb_ad_oe   = reg_we;
                lb_ad_out  = reg_we ? reg_wdata : '0;
            end
            ST_REG_DONE: begin
                reg_ack = 1'b1;
            end
            ST_PF_ADDR: begin
                lb_ads_n = 1'b0;
                lb_ad_oe = 1'b1;
            end
            ST_PF_DATA: begin
                lb_blast_n = !pf_last;
                push       = !lb_ready_n;
            end
            default: begin
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
        end else if (state == ST_REG_DATA && !lb_ready_n && !reg_we) begin
            reg_rdata <= lb_ad_in;
        end
    end

endmodule

// File: rtl/lbm_prefetch_master.sv
`timescale 1ns/1ps
module lbm_prefetch_master
    import lbm_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic              reg_ack,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              pf_valid,
    output logic [DATA_W-1:0] pf_data,
    input  logic              pf_ready,
    output logic [CNT_W-1:0]  pf_count,
    output logic              pf_full,
    output logic              pf_empty,
    output logic              lb_ads_n,
    output logic [DATA_W-1:0] lb_ad_out,
    output logic              lb_ad_oe,
    input  logic [DATA_W-1:0] lb_ad_in,
    output logic              lb_wnr,
    output logic              lb_blast_n,
    input  logic              lb_ready_n
);
    lbm_state_t state;
    logic       push;

    assign pf_valid = !pf_empty;

    lbm_seq #(
        .DATA_W (DATA_W),
        .ADDR_W (ADDR_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_req    (reg_req),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_ack    (reg_ack),
        .reg_rdata  (reg_rdata),
        .fifo_count (pf_count),
        .fifo_full  (pf_full),
        .push       (push),
        .lb_ads_n   (lb_ads_n),
        .lb_ad_out  (lb_ad_out),
        .lb_ad_oe   (lb_ad_oe),
        .lb_ad_in   (lb_ad_in),
        .lb_wnr     (lb_wnr),
        .lb_blast_n (lb_blast_n),
        .lb_ready_n (lb_ready_n),
        .state      (state)
    );

    lbm_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH),
        .CNT_W  (CNT_W)
    ) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (lb_ad_in),
        .pop       (pf_ready),
        .head      (pf_data),
        .count     (pf_count),
        .full      (pf_full),
        .empty     (pf_empty)
    );

endmodule

// File: rtl/lbm_checker.sv
`timescale 1ns/1ps
module lbm_checker
    import lbm_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input lbm_state_t       state,
    input logic             reg_req,
    input logic             reg_ack,
    input logic             push,
    input logic             pf_valid,
    input logic             pf_ready,
    input logic [CNT_W-1:0] pf_count,
    input logic             pf_full,
    input logic             pf_empty,
    input logic             lb_ads_n,
    input logic             lb_blast_n
);
    // R1: first cycle out of reset is idle
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (lb_ads_n && lb_blast_n && !reg_ack && pf_empty));

    // R2: an address strobe lasts exactly one cycle
    a_r2_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !lb_ads_n |=> lb_ads_n);

    // R5: no burst starts from a full FIFO
    a_r5_no_start_full: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && pf_full) |=> (state != ST_PF_ADDR));

    // R6: a removal without a store lowers the count by one
    a_r6_pop_counts: assert property (@(posedge clk) disable iff (!rst_n)
        (pf_valid && pf_ready && !push) |=> (pf_count == $past(pf_count) - CNT_W'(1)));

    // R7: a request in a data cycle moves straight to the register address phase
    a_r7_interrupt: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PF_DATA && reg_req) |=> (state == ST_REG_ADDR));

    // R8: count bounded by depth
    a_r8_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        pf_count <= CNT_W'(DEPTH));

    // R8: the store that fills the FIFO carries burst-last
    a_r8_full_blast: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pf_count == CNT_W'(DEPTH - 1)) |-> !lb_blast_n);

    // R10: register request wins in IDLE
    a_r10_priority: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && reg_req) |=> (state == ST_REG_ADDR));

endmodule

bind lbm_prefetch_master lbm_checker #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
) u_lbm_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (state),
    .reg_req    (reg_req),
    .reg_ack    (reg_ack),
    .push       (push),
    .pf_valid   (pf_valid),
    .pf_ready   (pf_ready),
    .pf_count   (pf_count),
    .pf_full    (pf_full),
    .pf_empty   (pf_empty),
    .lb_ads_n   (lb_ads_n),
    .lb_blast_n (lb_blast_n)
);

// File: tb/test_lbm_prefetch_master.sv
`timescale 1ns/1ps
module test_lbm_prefetch_master;
    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;
    localparam int DEPTH  = 16;
    localparam int CNT_W  = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              reg_req = 1'b0, reg_we = 1'b0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic              reg_ack;
    logic [DATA_W-1:0] reg_rdata;
    logic              pf_valid, pf_ready = 1'b0;
    logic [DATA_W-1:0] pf_data;
    logic [CNT_W-1:0]  pf_count;
    logic              pf_full, pf_empty;
    logic              lb_ads_n, lb_ad_oe, lb_wnr, lb_blast_n;
    logic [DATA_W-1:0] lb_ad_out;
    logic [DATA_W-1:0] lb_ad_in = '0;
    logic              lb_ready_n = 1'b1;

    int  checks = 0;
    int  errors = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    lbm_prefetch_master #(
        .DATA_W (DATA_W), .ADDR_W (ADDR_W), .DEPTH (DEPTH), .CNT_W (CNT_W)
    ) i_lbm_prefetch_master (
        .clk (clk), .rst_n (rst_n),
        .reg_req (reg_req), .reg_we (reg_we), .reg_addr (reg_addr), .reg_wdata (reg_wdata),
        .reg_ack (reg_ack), .reg_rdata (reg_rdata),
        .pf_valid (pf_valid), .pf_data (pf_data), .pf_ready (pf_ready),
        .pf_count (pf_count), .pf_full (pf_full), .pf_empty (pf_empty),
        .lb_ads_n (lb_ads_n), .lb_ad_out (lb_ad_out), .lb_ad_oe (lb_ad_oe),
        .lb_ad_in (lb_ad_in), .lb_wnr (lb_wnr), .lb_blast_n (lb_blast_n),
        .lb_ready_n (lb_ready_n)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] pf_word(input int k);
        return 32'h5000_0000 + 32'(k) * 32'h0001_0003;
    endfunction

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got 0 expected 1 (run ended)");
            summary();
            $finish;
        end
    end

    // random-phase models
    logic [31:0]       q[$];
    logic [31:0]       mem [16];
    bit                in_data, d_pf, d_wnr;
    logic [3:0]        d_addr;
    bit                h_req, h_we, old_req;
    logic [3:0]        h_addr;
    logic [31:0]       h_wdata;
    int                wcnt;
    int                sz;

    initial begin
        // ---------- reset ----------
        repeat (3) @(negedge clk);
        #1;
        chk("R1 ads_n in reset", 32'(lb_ads_n), 1);
        chk("R1 empty in reset", 32'(pf_empty), 1);
        @(negedge clk); rst_n = 1'b1;
        #1;
        chk("R1 blast_n after reset", 32'(lb_blast_n), 1);
        chk("R1 oe after reset", 32'(lb_ad_oe), 0);
        chk("R1 ack after reset", 32'(reg_ack), 0);
        chk("R1 count after reset", 32'(pf_count), 0);
        chk("R1 valid after reset", 32'(pf_valid), 0);

        // ---------- R2 register write ----------
        @(negedge clk); reg_req = 1; reg_we = 1; reg_addr = 16'h0012; reg_wdata = 32'hA5A5_0F0F;
        @(negedge clk); #1;
        chk("R2 addr strobe", 32'(lb_ads_n), 0);
        chk("R2 addr value", lb_ad_out, 32'h12);
        chk("R2 addr wnr", 32'(lb_wnr), 1);
        chk("R2 addr oe", 32'(lb_ad_oe), 1);
        @(negedge clk); #1;
        chk("R2 data strobe off", 32'(lb_ads_n), 1);
        chk("R2 data blast", 32'(lb_blast_n), 0);
        chk("R2 data value", lb_ad_out, 32'hA5A5_0F0F);
        @(negedge clk); lb_ready_n = 0; #1;
        chk("R2 no early ack", 32'(reg_ack), 0);
        chk("R2 data still driven", lb_ad_out, 32'hA5A5_0F0F);
        @(negedge clk); reg_req = 0; lb_ready_n = 1; #1;
        chk("R2 ack", 32'(reg_ack), 1);
        @(negedge clk); #1;
        chk("R2 back to idle", 32'(lb_ads_n), 1);

        // ---------- R3 register read ----------
        @(negedge clk); reg_req = 1; reg_we = 0; reg_addr = 16'h0034;
        @(negedge clk); #1;
        chk("R3 addr value", lb_ad_out, 32'h34);
        chk("R3 addr wnr", 32'(lb_wnr), 0);
        @(negedge clk); lb_ready_n = 0; lb_ad_in = 32'hCAFE_0001; #1;
        chk("R3 data oe", 32'(lb_ad_oe), 0);
        chk("R3 data blast", 32'(lb_blast_n), 0);
        @(negedge clk); reg_req = 0; lb_ready_n = 1; lb_ad_in = 32'h0; #1;
        chk("R3 ack", 32'(reg_ack), 1);
        chk("R3 rdata", reg_rdata, 32'hCAFE_0001);

        // ---------- R4/R6/R8 fill to full, R5 no start ----------
        @(negedge clk); lb_ready_n = 0;
        @(negedge clk); #1;
        chk("R4 pf strobe", 32'(lb_ads_n), 0);
        chk("R4 pf address zero", lb_ad_out, 0);
        chk("R4 pf wnr", 32'(lb_wnr), 0);
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk); lb_ad_in = pf_word(k); lb_ready_n = 0; #1;
            chk("R11 count during fill", 32'(pf_count), 32'(k));
            chk("R8 blast at near-full", 32'(lb_blast_n), (k == DEPTH - 1) ? 0 : 1);
            chk("R4 pf data oe", 32'(lb_ad_oe), 0);
        end
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); lb_ready_n = 0; #1;
            chk("R5 no strobe when full", 32'(lb_ads_n), 1);
            chk("R8 full flag", 32'(pf_full), 1);
        end
        for (int k = 0; k < DEPTH; k++) begin
            @(negedge clk); lb_ready_n = 1; pf_ready = 1; #1;
            chk("R6 valid", 32'(pf_valid), 1);
            chk("R6 order", pf_data, pf_word(k));
        end
        @(negedge clk); pf_ready = 0; #1;
        chk("R11 empty after drain", 32'(pf_empty), 1);

        // ---------- R7 interrupt, R9 resume ----------
        @(negedge clk); lb_ready_n = 0;
        @(negedge clk); lb_ready_n = 0;
        @(negedge clk); lb_ad_in = 32'h7700_0000; lb_ready_n = 0; #1;
        chk("R7 no blast before request", 32'(lb_blast_n), 1);
        @(negedge clk); reg_req = 1; reg_we = 1; reg_addr = 16'h0056; reg_wdata = 32'h1111_2222;
        lb_ad_in = 32'h7700_0001; #1;
        chk("R7 blast on request", 32'(lb_blast_n), 0);
        @(negedge clk); #1;
        chk("R7 register strobe next", 32'(lb_ads_n), 0);
        chk("R7 register address", lb_ad_out, 32'h56);
        chk("R7 last word stored", 32'(pf_count), 2);
        @(negedge clk); lb_ready_n = 0; #1;
        chk("R7 write data", lb_ad_out, 32'h1111_2222);
        @(negedge clk); reg_req = 0; lb_ready_n = 0; #1;
        chk("R9 ack", 32'(reg_ack), 1);
        @(negedge clk); lb_ready_n = 1; #1;
        chk("R9 resume strobe", 32'(lb_ads_n), 0);
        chk("R9 resume address", lb_ad_out, 0);
        @(negedge clk); reg_req = 1; reg_we = 0; reg_addr = 16'h0009; lb_ready_n = 1; #1;
        chk("R7 blast while slave not ready", 32'(lb_blast_n), 0);
        @(negedge clk); #1;
        chk("R7 read strobe", 32'(lb_ads_n), 0);
        @(negedge clk); lb_ready_n = 0; lb_ad_in = 32'hBEEF_0009;
        @(negedge clk); reg_req = 0; lb_ready_n = 1; #1;
        chk("R3 rdata after interrupt", reg_rdata, 32'hBEEF_0009);
        chk("R7 no store without ready", 32'(pf_count), 2);
        @(negedge clk); pf_ready = 1; #1;
        chk("R6 interrupted word 0", pf_data, 32'h7700_0000);
        @(negedge clk); #1;
        chk("R6 interrupted word 1", pf_data, 32'h7700_0001);
        @(negedge clk); pf_ready = 0;

        // ---------- R10 priority ----------
        @(negedge clk); reg_req = 1; reg_we = 0; reg_addr = 16'h0078; lb_ready_n = 0;
        @(negedge clk); #1;
        chk("R10 register first", lb_ad_out, 32'h78);
        chk("R10 register wnr", 32'(lb_wnr), 0);
        @(negedge clk); lb_ready_n = 0; lb_ad_in = 32'h0000_0078;
        @(negedge clk); reg_req = 0; lb_ready_n = 1; #1;
        chk("R10 ack", 32'(reg_ack), 1);
        @(negedge clk); #1;
        chk("R10 idle after", 32'(lb_ads_n), 1);

        // ---------- random mix ----------
        void'($urandom(32'd4711));
        for (int i = 0; i < 16; i++) mem[i] = 32'hA000_0000 + 32'(i);
        in_data = 0; h_req = 0; wcnt = 0;
        for (int cyc = 0; cyc < 4000; cyc++) begin
            @(negedge clk);
            old_req = h_req;
            chk("R11 count tracks model", 32'(pf_count), 32'(q.size()));
            if (reg_ack) begin
                chk("R2 ack only with request", 32'(h_req), 1);
                if (!h_we) chk("R3 random rdata", reg_rdata, mem[h_addr]);
                h_req = 0;
            end else if (!h_req && ($urandom % 6) == 0) begin
                h_req = 1; h_we = $urandom % 2; h_addr = 4'($urandom); h_wdata = $urandom;
            end
            reg_req = h_req; reg_we = h_we; reg_addr = 16'(h_addr); reg_wdata = h_wdata;
            lb_ready_n = (($urandom % 3) == 0);
            pf_ready = (($urandom % 4) != 0);
            if (in_data && d_pf) lb_ad_in = 32'h3000_0000 + 32'(wcnt);
            else if (in_data && !d_wnr) lb_ad_in = mem[d_addr];
            else lb_ad_in = $urandom;
            #1;
            sz = q.size();
            chk("R11 valid matches model", 32'(pf_valid), (sz > 0) ? 1 : 0);
            if (pf_valid && pf_ready) begin
                chk("R6 random order", pf_data, q[0]);
                void'(q.pop_front());
            end
            if (in_data) begin
                if (d_pf) begin
                    if (h_req) chk("R7 random blast", 32'(lb_blast_n), 0);
                    if (sz >= DEPTH - 1) chk("R8 random blast", 32'(lb_blast_n), 0);
                    if (!lb_ready_n) begin q.push_back(lb_ad_in); wcnt++; end
                    if (!lb_blast_n) in_data = 0;
                end else begin
                    chk("R2 random data blast", 32'(lb_blast_n), 0);
                    if (d_wnr) chk("R2 random write data", lb_ad_out, h_wdata);
                    if (!lb_ready_n) begin
                        if (d_wnr) mem[d_addr] = lb_ad_out;
                        in_data = 0;
                    end
                end
            end
            if (!lb_ads_n) begin
                if (old_req) begin
                    chk("R10 random register address", lb_ad_out, 32'(h_addr));
                    chk("R2 random wnr", 32'(lb_wnr), 32'(h_we));
                end else begin
                    chk("R4 random pf address", lb_ad_out, 0);
                    chk("R5 random start not full", 32'(sz < DEPTH), 1);
                end
                in_data = 1; d_pf = !old_req; d_wnr = lb_wnr; d_addr = lb_ad_out[3:0];
            end
        end

        done = 1;
        summary();
        $finish;
    end

endmodule